// File: doc/BRIEF.md
# PCM Time-Slot Assigner

This block connects one codec channel to a serial PCM highway. Its transmit and receive sides are independent. Each side has its own frame-sync input, which marks the start of a frame. Each side counts bit clocks from that marker, works out the current slot number, and compares it with a programmed slot. In the matching slot, the transmit side shifts an 8-bit sample onto one of its data lines, most significant bit first. Outside that slot every transmit line is left undriven: a per-port output enable is low and the data bit is forced to 0. In the matching slot, the receive side shifts 8 bits in from the selected receive line and presents them as a parallel sample.

Software sets up the block through a byte-wide write port, gated by an active-low chip select. Three targets can be written: the transmit assignment, the receive assignment and the timing mode. An assignment byte holds an enable bit, a port-select bit and a slot number. A write always takes effect in two steps. Writing a side silences it at once. The new assignment then goes live only on the second frame that starts after chip select returns high. The timing mode is either non-delayed, where the slot begins right after the edge that sees frame sync rise, or delayed, where frame sync marks the clock before bit 0 of slot 0 and any slot can be reached. The clock input is the PCM bit clock: one clock period is one bit period.

Each side has its own control state machine, with these states:
- `SIDE_OFF`: idle and silent.
- `SIDE_HOLD`: a write to this side is in progress.
- `SIDE_WAIT1`: committed, waiting for the first frame start.
- `SIDE_WAIT2`: waiting for the second frame start.
- `SIDE_LIVE`: the port is active.

Its transitions are:
- `write_hit`: from any state to `SIDE_HOLD` while chip select is low and this side is addressed.
- `commit_on`: `SIDE_HOLD` to `SIDE_WAIT1` when chip select rises and the enable bit is 1.
- `commit_off`: `SIDE_HOLD` to `SIDE_OFF` when chip select rises and the enable bit is 0.
- `first_frame`: `SIDE_WAIT1` to `SIDE_WAIT2` on a frame start.
- `second_frame`: `SIDE_WAIT2` to `SIDE_LIVE` on a frame start. This frame is already active.

Top module: `pcm_slot_port`

## Requirements
- R1: After reset, every `dx_oe` bit is 0, `rx_valid` is 0, `rx_sample` is 0, both sides are in `SIDE_OFF` and the timing mode is non-delayed.
- R2: The write target is chosen by `ctl_addr`: 0 is transmit, 1 is receive, 2 is mode. The mode byte selects delayed timing when its bit 0 is 1. An assignment byte has bit 7 as enable, bit 6 as port select and bits 5..0 as the slot number. The byte present in the last clock with `ctl_cs_n` low is committed on the clock edge that first sees `ctl_cs_n` high again.
- R3: In delayed mode, bit k of a frame occupies the k-th clock period after the first clock edge that follows the edge that sampled the frame sync high (k counts from 0). Slot s covers bits 8s to 8s+7. The transmit side drives `tx_sample`, MSB first, taking the sample in the slot's first bit period.
- R4: In non-delayed mode, bit 0 is the clock period right after the edge that samples the frame sync rise. The slot field is not used, so the port always works on slot 0.
- R5: An enabled assignment becomes active on the second frame-sync rise of that side after the commit edge. The frame started by that rise is served in full.
- R6: While chip select is low and addresses a side, that side is silent from the next clock period on. No transmit enable is driven, and no receive sample is completed after the one in flight.
- R7: With the enable bit at 0, no `dx_oe` bit rises, no `rx_valid` pulse occurs and `rx_sample` keeps its value.
- R8: Port select 0 or 1 chooses which `dx_oe`/`dx_data` pair and which `dr` line are used. At most one `dx_oe` bit is ever high, and the other port stays silent.
- R9: The receive side shifts the selected `dr` line in, MSB first. In the clock period after the slot's last bit, `rx_valid` is 1 for exactly one period and `rx_sample` holds the 8 received bits.
- R10: Each side counts from its own frame sync, so the two frame syncs may have any offset in whole clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCM bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_cs_n | input | 1 | Control chip select, active low |
| ctl_addr | input | 2 | Write target: 0 transmit, 1 receive, 2 mode |
| ctl_data | input | 8 | Control byte |
| fsx | input | 1 | Transmit frame sync |
| fsr | input | 1 | Receive frame sync |
| tx_sample | input | SAMPLE_W | Parallel sample to send |
| dx_data | output | NPORT | Transmit serial data per port, 0 when not enabled |
| dx_oe | output | NPORT | Transmit output enable per port (1 = drive the line) |
| dr | input | NPORT | Receive serial data per port |
| rx_sample | output | SAMPLE_W | Last received sample |
| rx_valid | output | 1 | One-cycle pulse when `rx_sample` is updated |

## Verification
The bench builds the block with `SLOT_W = 4`, so a frame is 16 slots (128 bit periods), and with `NPORT = 2`. The short frame lets each scenario run whole frames. This brings the last slot and the behaviour at the end of a frame within easy reach. It also covers the two-frame activation delay and a rewrite in the middle of a live slot. Two ports let the bench check port steering and show that the unused port stays silent. The bench also drives each side's frame sync with an offset to test independent phasing.

// File: rtl/pcm_tsa_pkg.sv
package pcm_tsa_pkg;

    localparam logic [1:0] ADDR_TX   = 2'd0;
    localparam logic [1:0] ADDR_RX   = 2'd1;
    localparam logic [1:0] ADDR_MODE = 2'd2;

    localparam int CFG_EN_BIT = 7;
    localparam int CFG_PS_BIT = 6;

    typedef enum logic [2:0] {
        SIDE_OFF,
        SIDE_HOLD,
        SIDE_WAIT1,
        SIDE_WAIT2,
        SIDE_LIVE
    } side_state_e;

endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer #(
    parameter int SLOT_W = 6,
    parameter int BIT_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fs,
    input  logic                     delayed,
    output logic                     frame_start,
    output logic                     running,
    output logic [SLOT_W+BIT_W-1:0]  pos
);
    localparam int PW = SLOT_W + BIT_W;
    localparam logic [PW-1:0] LAST_POS = '1;

    logic fs_q;
    logic pre_q;

    assign frame_start = fs && !fs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q    <= 1'b0;
            pre_q   <= 1'b0;
            running <= 1'b0;
            pos     <= '0;
        end else begin
            fs_q <= fs;
            if (frame_start) begin
                pos <= '0;
                if (delayed) begin
                    pre_q   <= 1'b1;
                    running <= 1'b0;
                end else begin
                    pre_q   <= 1'b0;
                    running <= 1'b1;
                end
            end else if (pre_q) begin
                pre_q   <= 1'b0;
                running <= 1'b1;
                pos     <= '0;
            end else if (running) begin
                if (pos == LAST_POS) begin
                    running <= 1'b0;
                end else begin
                    pos <= pos + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pcm_side_ctl.sv
module pcm_side_ctl
    import pcm_tsa_pkg::*;
#(
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              write_hit,
    input  logic              commit,
    input  logic [7:0]        cfg_byte,
    input  logic              frame_start,
    output logic              live,
    output logic              port_sel,
    output logic [SLOT_W-1:0] slot
);
    side_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= SIDE_OFF;
            port_sel <= 1'b0;
            slot     <= '0;
        end else begin
            state_q <= state_d;
            if (commit) begin
                port_sel <= cfg_byte[CFG_PS_BIT];
                slot     <= cfg_byte[SLOT_W-1:0];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SIDE_OFF:   if (write_hit) state_d = SIDE_HOLD;
            SIDE_HOLD:  if (commit)    state_d = cfg_byte[CFG_EN_BIT] ? SIDE_WAIT1 : SIDE_OFF;
            SIDE_WAIT1: if (write_hit) state_d = SIDE_HOLD;
                        else if (frame_start) state_d = SIDE_WAIT2;
            SIDE_WAIT2: if (write_hit) state_d = SIDE_HOLD;
                        else if (frame_start) state_d = SIDE_LIVE;
            SIDE_LIVE:  if (write_hit) state_d = SIDE_HOLD;
            default:    state_d = SIDE_OFF;
        endcase
    end

    always_comb begin
        live = (state_q == SIDE_LIVE);
    end
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
    import pcm_tsa_pkg::*;
#(
    parameter int SLOT_W   = 6,
    parameter int SAMPLE_W = 8,
    parameter int NPORT    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_cs_n,
    input  logic [1:0]          ctl_addr,
    input  logic [7:0]          ctl_data,
    input  logic                fsx,
    input  logic                fsr,
    input  logic [SAMPLE_W-1:0] tx_sample,
    output logic [NPORT-1:0]    dx_data,
    output logic [NPORT-1:0]    dx_oe,
    input  logic [NPORT-1:0]    dr,
    output logic [SAMPLE_W-1:0] rx_sample,
    output logic                rx_valid
);
    localparam int BIT_W = $clog2(SAMPLE_W);
    localparam int PW    = SLOT_W + BIT_W;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SAMPLE_W - 1);

    // control write capture
    logic       cs_q;
    logic [1:0] addr_h;
    logic [7:0] data_h;
    logic       delayed_q;
    logic       commit;

    assign commit = ctl_cs_n && !cs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q      <= 1'b1;
            addr_h    <= '0;
            data_h    <= '0;
            delayed_q <= 1'b0;
        end else begin
            cs_q <= ctl_cs_n;
            if (!ctl_cs_n) begin
                addr_h <= ctl_addr;
                data_h <= ctl_data;
            end
            if (commit && addr_h == ADDR_MODE) begin
                delayed_q <= data_h[0];
            end
        end
    end

    // per-side timing and control
    logic              tx_fstart, rx_fstart, tx_run, rx_run;
    logic [PW-1:0]     tx_pos, rx_pos;
    logic              tx_live, rx_live, tx_ps, rx_ps;
    logic [SLOT_W-1:0] tx_slot, rx_slot;

    pcm_frame_timer #(.SLOT_W(SLOT_W), .BIT_W(BIT_W)) u_tx_timer (
        .clk(clk), .rst_n(rst_n), .fs(fsx), .delayed(delayed_q),
        .frame_start(tx_fstart), .running(tx_run), .pos(tx_pos)
    );
    pcm_frame_timer #(.SLOT_W(SLOT_W), .BIT_W(BIT_W)) u_rx_timer (
        .clk(clk), .rst_n(rst_n), .fs(fsr), .delayed(delayed_q),
        .frame_start(rx_fstart), .running(rx_run), .pos(rx_pos)
    );
    pcm_side_ctl #(.SLOT_W(SLOT_W)) u_tx_ctl (
        .clk(clk), .rst_n(rst_n),
        .write_hit(!ctl_cs_n && ctl_addr == ADDR_TX),
        .commit(commit && addr_h == ADDR_TX),
        .cfg_byte(data_h), .frame_start(tx_fstart),
        .live(tx_live), .port_sel(tx_ps), .slot(tx_slot)
    );
    pcm_side_ctl #(.SLOT_W(SLOT_W)) u_rx_ctl (
        .clk(clk), .rst_n(rst_n),
        .write_hit(!ctl_cs_n && ctl_addr == ADDR_RX),
        .commit(commit && addr_h == ADDR_RX),
        .cfg_byte(data_h), .frame_start(rx_fstart),
        .live(rx_live), .port_sel(rx_ps), .slot(rx_slot)
    );

    // transmit path
    logic [SLOT_W-1:0]   tx_slot_eff;
    logic                tx_in, tx_first, tx_bit;
    logic [SAMPLE_W-1:0] tx_sh;

    assign tx_slot_eff = delayed_q ? tx_slot : '0;
    assign tx_in    = tx_live && tx_run && (tx_pos[PW-1:BIT_W] == tx_slot_eff);
    assign tx_first = tx_in && (tx_pos[BIT_W-1:0] == '0);
    assign tx_bit   = tx_first ? tx_sample[SAMPLE_W-1] : tx_sh[SAMPLE_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh <= '0;
        end else if (tx_first) begin
            tx_sh <= tx_sample << 1;
        end else if (tx_in) begin
            tx_sh <= tx_sh << 1;
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_dx
        assign dx_oe[p]   = tx_in && (tx_ps == 1'(p));
        assign dx_data[p] = dx_oe[p] && tx_bit;
    end

    // receive path
    logic [SLOT_W-1:0]   rx_slot_eff;
    logic                rx_in, rx_bit;
    logic [SAMPLE_W-1:0] rx_sh;

    assign rx_slot_eff = delayed_q ? rx_slot : '0;
    assign rx_in = rx_live && rx_run && (rx_pos[PW-1:BIT_W] == rx_slot_eff);

    if (NPORT > 1) begin : g_rx_sel
        assign rx_bit = rx_ps ? dr[1] : dr[0];
    end else begin : g_rx_one
        assign rx_bit = dr[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh     <= '0;
            rx_sample <= '0;
            rx_valid  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (rx_in) begin
                rx_sh <= {rx_sh[SAMPLE_W-2:0], rx_bit};
                if (rx_pos[BIT_W-1:0] == LAST_BIT) begin
                    rx_sample <= {rx_sh[SAMPLE_W-2:0], rx_bit};
                    rx_valid  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pcm_slot_port_chk.sv
module pcm_slot_port_chk #(
    parameter int NPORT = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_cs_n,
    input logic [1:0]       ctl_addr,
    input logic [NPORT-1:0] dx_oe,
    input logic             rx_valid
);
    p_oe_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dx_oe));

    p_tx_silence_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_cs_n && ctl_addr == 2'd0) |=> (dx_oe == '0));

    p_rx_silence_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_cs_n && ctl_addr == 2'd1) |-> ##2 !rx_valid);

    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
endmodule

bind pcm_slot_port pcm_slot_port_chk #(.NPORT(NPORT)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_cs_n(ctl_cs_n), .ctl_addr(ctl_addr),
    .dx_oe(dx_oe), .rx_valid(rx_valid)
);

// File: tb/tb_pcm_slot_port.sv
`timescale 1ns/1ps
module tb_pcm_slot_port;
    localparam int SLOT_W = 4;
    localparam int SAMPLE_W = 8;
    localparam int NPORT = 2;
    localparam int FRAME_BITS = (1 << SLOT_W) * SAMPLE_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_cs_n = 1'b1;
    logic [1:0] ctl_addr = '0;
    logic [7:0] ctl_data = '0;
    logic fsx = 1'b0, fsr = 1'b0;
    logic [7:0] tx_sample = 8'hB4;
    logic [1:0] dx_data, dx_oe;
    logic [1:0] dr = '0;
    logic [7:0] rx_sample;
    logic rx_valid;

    int vectors = 0;
    int fails = 0;

    always #4 clk = ~clk;

    pcm_slot_port #(.SLOT_W(SLOT_W), .SAMPLE_W(SAMPLE_W), .NPORT(NPORT)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_cs_n(ctl_cs_n), .ctl_addr(ctl_addr),
        .ctl_data(ctl_data), .fsx(fsx), .fsr(fsr), .tx_sample(tx_sample),
        .dx_data(dx_data), .dx_oe(dx_oe), .dr(dr),
        .rx_sample(rx_sample), .rx_valid(rx_valid)
    );

    function automatic logic [7:0] byte_of(input int s);
        return 8'((s * 37 + 91) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); ctl_cs_n = 1'b0; ctl_addr = a; ctl_data = d;
        @(negedge clk); ctl_cs_n = 1'b1;
        @(negedge clk);
    endtask

    // One whole frame: checks transmit bits per period and the receive result.
    task automatic frame(input bit dly, input int rxd,
                         input bit txl, input int txs, input int txp,
                         input bit rxl, input int rxs, input int rxp,
                         input string req);
        int off = dly ? 1 : 0;
        int ts = dly ? txs : 0;
        int rs = dly ? rxs : 0;
        int bad = 0, nval = 0, act_bad = 0, exp_bad = 0;
        logic [7:0] prev = rx_sample;
        @(negedge clk); fsx = 1'b1; fsr = (rxd == 0);
        @(negedge clk); fsx = 1'b0; fsr = 1'b0;
        for (int i = 0; i < FRAME_BITS + off + rxd + 3; i++) begin
            int ct = i - off;
            int cr = i - off - rxd;
            logic [1:0] eo = '0, ed = '0;
            fsr = (rxd > 0 && i == rxd - 1);
            dr = '0;
            if (cr >= 0 && cr < FRAME_BITS) begin
                logic b = byte_of(cr / 8)[7 - (cr % 8)];
                dr[rxp] = b;
                dr[1 - rxp] = ~b;
            end
            if (txl && ct >= ts * 8 && ct < ts * 8 + 8) begin
                eo[txp] = 1'b1;
                ed[txp] = tx_sample[7 - (ct - ts * 8)];
            end
            if ((dx_oe !== eo || dx_data !== ed) && bad == 0) begin
                act_bad = {dx_oe, dx_data};
                exp_bad = {eo, ed};
            end
            if (dx_oe !== eo || dx_data !== ed) bad++;
            if (rx_valid) nval++;
            @(negedge clk);
        end
        dr = '0;
        chk(bad == 0, req, "transmit enable/data per bit period", act_bad, exp_bad);
        if (rxl)
            chk(nval == 1 && rx_sample == byte_of(rs), req, "receive sample",
                {nval, rx_sample}, {1, byte_of(rs)});
        else
            chk(nval == 0 && rx_sample == prev, req, "receive ignored",
                {nval, rx_sample}, {0, prev});
    endtask

    task automatic t_reset;
        chk(dx_oe == 2'b00, "R1", "dx_oe after reset", dx_oe, 0);
        chk(rx_valid == 1'b0 && rx_sample == 8'h00, "R1", "rx after reset",
            {rx_valid, rx_sample}, 0);
    endtask

    task automatic t_nondelayed;
        wr(2'd0, 8'h80); wr(2'd1, 8'h80);
        frame(0, 0, 0, 0, 0, 0, 0, 0, "R5");
        frame(0, 0, 1, 0, 0, 1, 0, 0, "R4");
    endtask

    task automatic t_nondelayed_field_ignored;
        wr(2'd0, 8'hC7); wr(2'd1, 8'hC5);
        frame(0, 0, 0, 0, 1, 0, 0, 1, "R5");
        frame(0, 0, 1, 7, 1, 1, 5, 1, "R4 R8");
    endtask

    task automatic t_delayed;
        wr(2'd2, 8'h01); wr(2'd0, 8'h85); wr(2'd1, 8'hC9);
        frame(1, 0, 0, 5, 0, 0, 9, 1, "R5");
        frame(1, 0, 1, 5, 0, 1, 9, 1, "R3 R9");
        frame(1, 3, 1, 5, 0, 1, 9, 1, "R10");
    endtask

    task automatic t_silence;
        int bad = 0;
        wr(2'd0, 8'h80);
        frame(1, 0, 0, 0, 0, 1, 9, 1, "R5");
        frame(1, 0, 1, 0, 0, 1, 9, 1, "R3");
        @(negedge clk); fsx = 1'b1;
        @(negedge clk); fsx = 1'b0;
        @(negedge clk);
        chk(dx_oe == 2'b01, "R3", "slot 0 first bit live", dx_oe, 1);
        ctl_cs_n = 1'b0; ctl_addr = 2'd0; ctl_data = 8'h80;
        @(negedge clk);
        chk(dx_oe == 2'b00, "R6", "silenced during write", dx_oe, 0);
        ctl_cs_n = 1'b1;
        for (int i = 0; i < FRAME_BITS; i++) begin
            @(negedge clk);
            if (dx_oe != 2'b00) bad++;
        end
        chk(bad == 0, "R6", "rest of frame silent", bad, 0);
        frame(1, 0, 0, 0, 0, 1, 9, 1, "R5");
        frame(1, 0, 1, 0, 0, 1, 9, 1, "R5");
    endtask

    task automatic t_disabled;
        wr(2'd0, 8'h05); wr(2'd1, 8'h09);
        frame(1, 0, 0, 5, 0, 0, 9, 0, "R7");
        frame(1, 0, 0, 5, 0, 0, 9, 0, "R7");
    endtask

    task automatic t_last_slot;
        tx_sample = 8'h3C;
        wr(2'd0, 8'hCF); wr(2'd1, 8'h8F);
        frame(1, 0, 0, 15, 1, 0, 15, 0, "R2");
        frame(1, 0, 1, 15, 1, 1, 15, 0, "R2 R8 R9");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nondelayed();
        t_nondelayed_field_ignored();
        t_delayed();
        t_silence();
        t_disabled();
        t_last_slot();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule